// File: doc/BRIEF.md
# Load-Time Sanitizing Index Array with Remapped Register Numbering

This block holds a small array of element indices that steer a remapped register access. A loader fills the array from a stream of raw index values, one value per accepted transfer. It checks each value against the vector length (VL) only at that point and rewrites values that are out of range. The access side therefore needs no range comparison. It adds the stored index to a base register number to form a 7-bit register number, and it recognises only one special stored pattern.

Software picks a policy at the start of each load, and the block latches it for the array:
- **Clamp:** an out-of-range value becomes element 0.
- **Null marker:** the value becomes an all-ones marker. Reads through the marker return zero and writes through it are dropped.
- **Redirect:** the value becomes the marker, but accesses through it go to register 0 and behave as ordinary accesses.

The inbound index stream is valid/ready. A transfer happens only on a cycle where both are high. While `in_valid` is low the block keeps `in_ready` high and waits, and nothing is stored. `in_ready` is high only while a load is in progress. The read port is plain and combinational.

Top module: `idx_load_remap`

## Requirements
- R1: Synchronous active-high reset clears all 64 entries to 0, drops `in_ready` and `done`, and selects clamp policy for the array.
- R2: A `start` pulse while idle raises `in_ready` on the next cycle. Each `in_valid && in_ready` cycle stores one value at the next element position, starting from element 0. After the transfer of element VL-1, `in_ready` falls and `done` is high for exactly the one following cycle. `start` is ignored while a load is running.
- R3: With `cfg_mode` = 0 (clamp), a value greater than or equal to VL is stored as 0, and a smaller value is stored unchanged. For example, the values 1, 2345, 0, 2 with VL = 4 are stored as 1, 0, 0, 2.
- R4: With `cfg_mode` = 1 or 3 (null marker), an out-of-range value is stored as 8'hFF.
- R5: With `cfg_mode` = 2 (redirect), an out-of-range value is stored as 8'hFF. An access through such an entry gives `rd_regnum` = 0 with `rd_null` low.
- R6: For a stored entry other than 8'hFF, in the same cycle, `rd_regnum` = (`rd_base` + entry) mod 128, `rd_null` is low, and `rd_entry` shows the entry.
- R7: For an 8'hFF entry when the array's policy is not redirect, `rd_null` is high, `rd_regnum` is 0 and `acc_we_out` is low. In every other case `acc_we_out` equals `acc_we_in`.
- R8: Entries at positions VL and above are not written by a load and keep their earlier contents.
- R9: A `cfg_vl` above 64 is treated as 64. A `cfg_vl` of 0 accepts no values and pulses `done` on the cycle after `start`.
- R10: The policy and VL are captured at `start`. Changes to `cfg_mode` or `cfg_vl` after that affect neither the stored values nor how accesses are interpreted until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (sampled while idle) |
| cfg_vl | input | 7 | Vector length for the load |
| cfg_mode | input | 2 | Policy: 0 clamp, 1/3 marker, 2 redirect |
| in_valid | input | 1 | Raw index value present |
| in_ready | output | 1 | Loader accepts a value |
| in_data | input | 16 | Raw index value |
| done | output | 1 | One-cycle pulse when a load completes |
| rd_elem | input | 6 | Element number to access |
| rd_base | input | 7 | Base register number |
| acc_we_in | input | 1 | Write requested by the access |
| rd_entry | output | 8 | Stored entry for `rd_elem` |
| rd_regnum | output | 7 | Remapped register number |
| rd_null | output | 1 | Access goes through a null marker |
| acc_we_out | output | 1 | Write enable after suppression |

## Verification
A wrongly stored entry stays hidden until that element is addressed. At that point it shows in the same cycle on `rd_entry`, `rd_regnum` and possibly `rd_null`, so the bench sweeps every element after each load. A slip in the element counter or the latched VL shows up as `done` on the wrong cycle and `in_ready` open for the wrong number of transfers. A wrong latched policy appears only when a marker entry is accessed, where `rd_null` and `acc_we_out` disagree with the policy captured at `start`.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;
  typedef enum logic [1:0] {
    MODE_CLAMP = 2'd0,
    MODE_MARK  = 2'd1,
    MODE_REDIR = 2'd2,
    MODE_MARK2 = 2'd3
  } remap_mode_e;

  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;
endpackage

// File: rtl/idx_load_ctrl.sv
module idx_load_ctrl
  import idx_remap_pkg::*;
#(
  parameter int MAX_ELEM = 64,
  parameter int VL_W     = 7,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VL_W-1:0]  cfg_vl,
  input  logic [1:0]       cfg_mode,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             done,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output logic [VL_W-1:0]  vl_q,
  output remap_mode_e      mode_q
);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_ELEM);

  ld_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [VL_W-1:0]  eff_vl;
  logic             last_elem;

  // cap the requested length at the array depth
  assign eff_vl    = (cfg_vl > VL_CAP) ? VL_CAP : cfg_vl;
  assign last_elem = (VL_W'(cnt) == (vl_q - VL_W'(1)));
  assign in_ready  = (state == LD_RUN);
  assign wr_en     = in_ready && in_valid;
  assign wr_addr   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= LD_IDLE;
      cnt    <= '0;
      vl_q   <= '0;
      mode_q <= MODE_CLAMP;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        LD_IDLE: begin
          if (start) begin
            vl_q   <= eff_vl;
            mode_q <= remap_mode_e'(cfg_mode);
            cnt    <= '0;
            if (eff_vl == '0) done  <= 1'b1;
            else              state <= LD_RUN;
          end
        end
        LD_RUN: begin
          if (in_valid) begin
            cnt <= cnt + CNT_W'(1);
            if (last_elem) begin
              state <= LD_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_sanitize.sv
module idx_sanitize
  import idx_remap_pkg::*;
#(
  parameter int DIN_W = 16,
  parameter int VL_W  = 7,
  parameter int IDX_W = 8
) (
  input  logic [DIN_W-1:0] raw,
  input  logic [VL_W-1:0]  vl,
  input  remap_mode_e      mode,
  output logic [IDX_W-1:0] clean
);
  localparam logic [IDX_W-1:0] MARKER = '1;

  logic [DIN_W-1:0] vl_ext;
  logic             out_of_range;
  logic [IDX_W-1:0] replace;

  // the only comparison against VL lives here, on the load side
  assign vl_ext       = DIN_W'(vl);
  assign out_of_range = (raw >= vl_ext);

  generate
    if (IDX_W > VL_W) begin : g_wide
      assign replace = (mode == MODE_CLAMP) ? '0 : MARKER;
    end else begin : g_narrow
      assign replace = '0;
    end
  endgenerate

  assign clean = out_of_range ? replace : raw[IDX_W-1:0];
endmodule

// File: rtl/idx_store.sv
module idx_store #(
  parameter int MAX_ELEM = 64,
  parameter int IDX_W    = 8,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_addr,
  input  logic [IDX_W-1:0] wr_data,
  input  logic [CNT_W-1:0] rd_addr,
  output logic [IDX_W-1:0] rd_data
);
  logic [IDX_W-1:0] ent [MAX_ELEM];

  generate
    for (genvar g = 0; g < MAX_ELEM; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst)
          ent[g] <= '0;
        else if (wr_en && (wr_addr == CNT_W'(g)))
          ent[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = ent[rd_addr];
endmodule

// File: rtl/idx_remap.sv
module idx_remap
  import idx_remap_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int RN_W  = 7
) (
  input  logic [IDX_W-1:0] entry,
  input  logic [RN_W-1:0]  base,
  input  remap_mode_e      mode,
  input  logic             we_in,
  output logic [RN_W-1:0]  regnum,
  output logic             is_null,
  output logic             we_out
);
  logic            is_mark;
  logic [RN_W-1:0] sum;

  // marker test is a wide AND in parallel with the adder; no VL compare
  assign is_mark = &entry;
  assign sum     = base + entry[RN_W-1:0];
  assign regnum  = is_mark ? '0 : sum;
  assign is_null = is_mark && (mode != MODE_REDIR);
  assign we_out  = we_in && !is_null;
endmodule

// File: rtl/idx_load_remap.sv
module idx_load_remap
  import idx_remap_pkg::*;
#(
  parameter int MAX_ELEM = 64,
  parameter int DIN_W    = 16,
  parameter int IDX_W    = 8,
  parameter int RN_W     = 7,
  parameter int VL_W     = $clog2(MAX_ELEM + 1),
  parameter int CNT_W    = $clog2(MAX_ELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VL_W-1:0]  cfg_vl,
  input  logic [1:0]       cfg_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DIN_W-1:0] in_data,
  output logic             done,
  input  logic [CNT_W-1:0] rd_elem,
  input  logic [RN_W-1:0]  rd_base,
  input  logic             acc_we_in,
  output logic [IDX_W-1:0] rd_entry,
  output logic [RN_W-1:0]  rd_regnum,
  output logic             rd_null,
  output logic             acc_we_out
);
  logic             wr_en;
  logic [CNT_W-1:0] wr_addr;
  logic [VL_W-1:0]  vl_q;
  remap_mode_e      mode_q;
  logic [IDX_W-1:0] clean;

  idx_load_ctrl #(.MAX_ELEM(MAX_ELEM), .VL_W(VL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cfg_vl(cfg_vl), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .vl_q(vl_q), .mode_q(mode_q)
  );

  idx_sanitize #(.DIN_W(DIN_W), .VL_W(VL_W), .IDX_W(IDX_W)) u_san (
    .raw(in_data), .vl(vl_q), .mode(mode_q), .clean(clean)
  );

  idx_store #(.MAX_ELEM(MAX_ELEM), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(clean),
    .rd_addr(rd_elem), .rd_data(rd_entry)
  );

  idx_remap #(.IDX_W(IDX_W), .RN_W(RN_W)) u_remap (
    .entry(rd_entry), .base(rd_base), .mode(mode_q), .we_in(acc_we_in),
    .regnum(rd_regnum), .is_null(rd_null), .we_out(acc_we_out)
  );
endmodule

// File: rtl/idx_load_remap_chk.sv
module idx_load_remap_chk #(
  parameter int MAX_ELEM = 64,
  parameter int IDX_W    = 8,
  parameter int RN_W     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [RN_W-1:0]  rd_base,
  input logic             acc_we_in,
  input logic [IDX_W-1:0] rd_entry,
  input logic [RN_W-1:0]  rd_regnum,
  input logic             rd_null,
  input logic             acc_we_out,
  input logic [1:0]       mode_q
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!in_ready && !done));

  a_r2_done_closes_load: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  a_r2_stall_keeps_ready: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  a_r3_entry_legal: assert property (@(posedge clk) disable iff (rst)
    (rd_entry < IDX_W'(MAX_ELEM)) || (&rd_entry));

  a_r5_marker_to_r0: assert property (@(posedge clk) disable iff (rst)
    (&rd_entry) |-> (rd_regnum == '0));

  a_r6_sum: assert property (@(posedge clk) disable iff (rst)
    !(&rd_entry) |-> (!rd_null && rd_regnum == RN_W'(rd_base + rd_entry[RN_W-1:0])));

  a_r7_null_drops_write: assert property (@(posedge clk) disable iff (rst)
    rd_null |-> !acc_we_out);

  a_r7_write_passes: assert property (@(posedge clk) disable iff (rst)
    !rd_null |-> (acc_we_out == acc_we_in));

  a_r10_policy_held: assert property (@(posedge clk) disable iff (rst)
    (in_ready && $past(in_ready)) |-> $stable(mode_q));
endmodule

bind idx_load_remap idx_load_remap_chk #(.MAX_ELEM(MAX_ELEM), .IDX_W(IDX_W), .RN_W(RN_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .done(done),
  .rd_base(rd_base), .acc_we_in(acc_we_in), .rd_entry(rd_entry),
  .rd_regnum(rd_regnum), .rd_null(rd_null), .acc_we_out(acc_we_out),
  .mode_q(mode_q)
);

// File: tb/test_idx_load_remap.sv
`timescale 1ns/1ps
module test_idx_load_remap;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [6:0]  cfg_vl = 0;
  logic [1:0]  cfg_mode = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_data = 0;
  logic        done;
  logic [5:0]  rd_elem = 0;
  logic [6:0]  rd_base = 0;
  logic        acc_we_in = 0;
  logic [7:0]  rd_entry;
  logic [6:0]  rd_regnum;
  logic        rd_null;
  logic        acc_we_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  idx_load_remap i_idx_load_remap (
    .clk(clk), .rst(rst), .start(start), .cfg_vl(cfg_vl), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .done(done),
    .rd_elem(rd_elem), .rd_base(rd_base), .acc_we_in(acc_we_in),
    .rd_entry(rd_entry), .rd_regnum(rd_regnum), .rd_null(rd_null),
    .acc_we_out(acc_we_out)
  );

  // behavioural reference
  int m_arr [64];
  bit m_busy, m_done;
  int m_vl, m_mode, m_cnt;
  int regfile [128];

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_arr[i]) m_arr[i] = 0;
      m_busy = 0; m_done = 0; m_mode = 0; m_vl = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_vl = (cfg_vl > 64) ? 64 : int'(cfg_vl);
          m_mode = int'(cfg_mode);
          m_cnt = 0;
          if (m_vl == 0) m_done = 1; else m_busy = 1;
        end
      end else if (in_valid) begin
        if (int'(in_data) >= m_vl) m_arr[m_cnt] = (m_mode == 0) ? 0 : 255;
        else                        m_arr[m_cnt] = int'(in_data);
        m_cnt++;
        if (m_cnt == m_vl) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison with the reference
  always @(negedge clk) begin
    if (!rst) begin
      int e, en, er, ew;
      e  = m_arr[rd_elem];
      en = (e == 255) && (m_mode != 2);
      er = (e == 255) ? 0 : ((int'(rd_base) + e) % 128);
      ew = acc_we_in && !en;
      chk(in_ready == m_busy, "R2 in_ready", in_ready, m_busy);
      chk(done == m_done, "R2 done", done, m_done);
      chk(int'(rd_entry) == e, "R3,R4,R8 rd_entry", rd_entry, e);
      chk(int'(rd_regnum) == er, "R6 rd_regnum", rd_regnum, er);
      chk(rd_null == en, "R7 rd_null", rd_null, en);
      chk(acc_we_out == ew, "R7 acc_we_out", acc_we_out, ew);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic begin_load(input int vl, input int mode);
    cfg_vl = 7'(vl); cfg_mode = 2'(mode); start = 1;
    tick();
    start = 0;
  endtask

  task automatic push(input int v, input int gap);
    for (int g = 0; g < gap; g++) begin in_valid = 0; tick(); end
    in_valid = 1; in_data = 16'(v);
    tick();
    in_valid = 0;
  endtask

  task automatic peek(input int elem, input int base, input bit we);
    rd_elem = 6'(elem); rd_base = 7'(base); acc_we_in = we;
    @(negedge clk); #0.5;
  endtask

  task automatic sweep();
    for (int i = 0; i < 64; i++) begin
      rd_elem = 6'(i); rd_base = 7'((i * 37) % 128);
      tick();
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    chk(!in_ready && !done, "R1 idle after reset", in_ready, 0);
    for (int i = 0; i < 64; i += 9) begin
      peek(i, 5, 0);
      chk(rd_entry == 0, "R1 entry cleared", rd_entry, 0);
    end
    tick();

    // R3: clamp, the documented example
    begin_load(4, 0);
    chk(in_ready, "R2 ready after start", in_ready, 1);
    push(1, 0); push(2345, 0); push(0, 0); push(2, 0);
    @(negedge clk);
    chk(done && !in_ready, "R2 done pulse", done, 1);
    tick();
    chk(!done, "R2 done one cycle", done, 0);
    begin
      int src [4] = '{1, 0, 0, 2};
      for (int i = 0; i < 4; i++) regfile[20 + i] = 100 + i;
      for (int i = 0; i < 4; i++) begin
        int got;
        peek(i, 20, 0);
        got = rd_null ? 0 : regfile[rd_regnum];
        chk(got == 100 + src[i], "R3 remapped move source", got, 100 + src[i]);
      end
    end
    sweep();

    // R4 + R2 back-pressure gaps: marker mode
    begin_load(5, 1);
    push(4, 2); push(7, 0); push(3, 3); push(5, 1); push(0, 0);
    @(negedge clk); #0.5;
    chk(done, "R2 done after stalls", done, 1);
    peek(1, 9, 0);
    chk(rd_entry == 8'hFF, "R4 marker stored", rd_entry, 255);
    // R7: write through marker suppressed, read yields zero
    foreach (regfile[i]) regfile[i] = 7;
    for (int i = 0; i < 5; i++) begin
      peek(i, 9, 1);
      if (acc_we_out) regfile[rd_regnum] = 55;
    end
    chk(regfile[0] == 7, "R7 marker write dropped", regfile[0], 7);
    chk(regfile[13] == 55 && regfile[12] == 55 && regfile[9] == 55,
        "R7 normal writes land", regfile[13], 55);
    peek(3, 9, 1);
    chk(rd_null && !acc_we_out && rd_regnum == 0, "R7 null access", rd_null, 1);
    sweep();

    // R5 redirect, R8 upper entries untouched
    begin_load(3, 2);
    push(2, 0); push(99, 0); push(1, 0);
    tick();
    peek(1, 10, 1);
    chk(rd_entry == 8'hFF && rd_regnum == 0 && !rd_null && acc_we_out,
        "R5 redirect to r0", rd_regnum, 0);
    peek(3, 0, 0);
    chk(rd_entry == 8'hFF, "R8 elem3 kept", rd_entry, 255);
    peek(4, 0, 0);
    chk(rd_entry == 0, "R8 elem4 kept", rd_entry, 0);
    peek(3, 0, 1);
    chk(!rd_null && rd_regnum == 0, "R5 old marker under redirect", rd_null, 0);
    sweep();

    // R6 wrap
    peek(0, 120, 0);
    chk(rd_regnum == 7'(122), "R6 base plus index", rd_regnum, 122);
    begin_load(30, 0);
    for (int i = 0; i < 30; i++) push(20, 0);
    tick();
    peek(5, 120, 0);
    chk(rd_regnum == 12, "R6 wrap mod 128", rd_regnum, 12);

    // R9: VL zero and VL above capacity
    begin_load(0, 1);
    @(negedge clk);
    chk(done && !in_ready, "R9 vl zero done", done, 1);
    tick();
    begin_load(100, 0);
    for (int i = 0; i < 64; i++) push(i * 2, (i % 7 == 0) ? 1 : 0);
    @(negedge clk);
    chk(done, "R9 capped at 64", done, 1);
    tick();
    peek(40, 0, 0);
    chk(rd_entry == 0, "R9 value 80 clamped", rd_entry, 0);
    peek(31, 0, 0);
    chk(rd_entry == 62, "R9 value 62 kept", rd_entry, 62);
    sweep();

    // R10: policy latched, start during load ignored
    begin_load(3, 0);
    cfg_mode = 1; cfg_vl = 1;
    push(0, 0);
    start = 1; push(9, 0); start = 0;
    push(1, 0);
    @(negedge clk);
    chk(done, "R10 load length held", done, 1);
    tick();
    peek(1, 4, 1);
    chk(rd_entry == 0 && !rd_null, "R10 policy held at clamp", rd_entry, 0);
    sweep();

    repeat (3) tick();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule